// File: doc/BRIEF.md
# APB UART Register Block

This block is the register side of a UART, sitting behind a zero-wait-state APB slave port. Received bytes arrive on a valid/ready byte stream and are queued in a receive FIFO. Software drains the FIFO by reading the data register, and each such read removes one byte. A write to the data register hands one byte to an outgoing valid/ready stream, provided the transmitter is enabled.

Software sees four live registers: data, status, control and an inert baud scaler. A single interrupt line pulses for one cycle when a byte is taken in or sent out. Each of the two causes has its own enable bit in the control register. Serial framing, baud timing, parity and flow control live elsewhere. The control bits for those functions are only stored here and read back.

Top module: `uart_apb_regs`

## Requirements
- R1: After reset, status reads 0x0000_0006, control reads 0, the receive FIFO is empty, the interrupt is low and no transmit byte is offered.
- R2: The status register at offset 0x04 has these bits. Bit 0 is set while the receive FIFO holds at least one byte. Bits 1 and 2 always read 1. Bit 8 is set while the FIFO holds at least DEPTH/2 bytes. Bit 10 is set while it holds DEPTH bytes. All other bits read 0.
- R3: A read at offset 0x00 or 0x03 returns the oldest received byte in bits 7:0, with zeros above, and removes that byte. On an empty FIFO the same read returns 0 and changes nothing.
- R4: An incoming byte is stored only while control bit 0 (receive enable) is 1. While that bit is 0, offered bytes are still taken (ready stays high) but they are thrown away.
- R5: The control register at offset 0x08 stores and returns all 32 written bits. Bit 0 enables receive, bit 1 enables transmit, bit 2 enables the receive interrupt and bit 3 enables the transmit interrupt.
- R6: During the access cycle of a write at offset 0x00 or 0x03 with control bit 1 set, the transmit stream is valid and carries write data bits 7:0. It is never valid otherwise.
- R7: Writes to status (0x04), scaler (0x0C) and any offset not listed are ignored. Scaler reads 0, as do offsets 0x10 and above. Only address bits 7:0 are decoded.
- R8: The interrupt is high for exactly the one cycle after a stored receive byte with control bit 2 set, or a completed transmit handshake with control bit 3 set. A receive cause and a transmit cause in the same cycle give one pulse.
- R9: While the FIFO holds DEPTH bytes, the receive stream's ready output is low and no byte is lost or overwritten.
- R10: A transmit write during which the output stream is not ready is dropped and raises no interrupt.
- R11: PREADY is always high and PSLVERR is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address; bits 7:0 decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rxData | input | 8 | Incoming byte |
| rxValid | input | 1 | Incoming byte valid |
| rxReady | output | 1 | Block can take a byte |
| txData | output | 8 | Outgoing byte |
| txValid | output | 1 | Outgoing byte valid |
| txReady | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Read data and the transmit valid/data are due in the same APB access cycle that causes them, because they are combinational. A push or pop shows up in status and rxReady from the next cycle on. The interrupt rises one clock after the handshake that causes it. The bench's model is stepped at each falling edge: it first compares the outputs against the state it built from earlier edges, then applies the current inputs to that state. Every result is therefore checked in exactly the cycle in which it is due.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  // Register byte offsets (decoded on address bits 7:0)
  localparam logic [7:0] OFF_DATA    = 8'h00;
  localparam logic [7:0] OFF_DATA_B3 = 8'h03;
  localparam logic [7:0] OFF_STATUS  = 8'h04;
  localparam logic [7:0] OFF_CTRL    = 8'h08;

  // Control bit positions
  localparam int CB_RX_EN  = 0;
  localparam int CB_TX_EN  = 1;
  localparam int CB_RX_IRQ = 2;
  localparam int CB_TX_IRQ = 3;

  typedef enum logic [1:0] {RD_NONE, RD_DATA, RD_STATUS, RD_CTRL} rdSel_e;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
  } uartStrobes_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         psel,
  input  logic         penable,
  input  logic         pwrite,
  input  logic [7:0]   addrLow,
  input  logic [31:0]  pwdata,
  input  logic         rxValid,
  input  logic         rxReady,
  input  logic         txReady,
  input  logic         fifoEmpty,
  output uartStrobes_t strobes,
  output rdSel_e       rdSel,
  output logic [31:0]  ctrlQ,
  output logic         txValid,
  output logic [7:0]   txData,
  output logic         irq
);

  logic accessPhase;
  logic isData;
  logic txDone;
  logic rxTaken;

  assign accessPhase = psel && penable;
  assign isData      = (addrLow == OFF_DATA) || (addrLow == OFF_DATA_B3);

  assign rxTaken        = rxValid && rxReady && ctrlQ[CB_RX_EN];
  assign strobes.rxPush = rxTaken;
  assign strobes.rxPop  = accessPhase && !pwrite && isData && !fifoEmpty;

  assign txValid = accessPhase && pwrite && isData && ctrlQ[CB_TX_EN];
  assign txData  = pwdata[7:0];
  assign txDone  = txValid && txReady;

  always_comb begin
    rdSel = RD_NONE;
    if (accessPhase && !pwrite) begin
      if (isData)                     rdSel = RD_DATA;
      else if (addrLow == OFF_STATUS) rdSel = RD_STATUS;
      else if (addrLow == OFF_CTRL)   rdSel = RD_CTRL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      irq   <= 1'b0;
    end else begin
      if (accessPhase && pwrite && (addrLow == OFF_CTRL)) ctrlQ <= pwdata;
      irq <= (rxTaken && ctrlQ[CB_RX_IRQ]) || (txDone && ctrlQ[CB_TX_IRQ]);
    end
  end

endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic         clk,
  input  logic         rstN,
  input  uartStrobes_t strobes,
  input  rdSel_e       rdSel,
  input  logic [31:0]  ctrlQ,
  input  logic [7:0]   rxData,
  output logic         rxReady,
  output logic         fifoEmpty,
  output logic [CNT_W-1:0] rxCount,
  output logic [31:0]  prdata
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [31:0]      statusWord;

  assign fifoEmpty = (rxCount == '0);
  assign rxReady   = (rxCount != FULL_CNT);

  always_ff @(posedge clk) begin
    if (strobes.rxPush) mem[wrPtr] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxCount <= '0;
    end else begin
      if (strobes.rxPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobes.rxPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobes.rxPush, strobes.rxPop})
        2'b10:   rxCount <= rxCount + 1'b1;
        2'b01:   rxCount <= rxCount - 1'b1;
        default: rxCount <= rxCount;
      endcase
    end
  end

  always_comb begin
    statusWord     = '0;
    statusWord[0]  = !fifoEmpty;
    statusWord[1]  = 1'b1;
    statusWord[2]  = 1'b1;
    statusWord[8]  = (rxCount >= HALF_CNT);
    statusWord[10] = (rxCount == FULL_CNT);
  end

  always_comb begin
    unique case (rdSel)
      RD_DATA:   prdata = fifoEmpty ? 32'h0 : {24'h0, mem[rdPtr]};
      RD_STATUS: prdata = statusWord;
      RD_CTRL:   prdata = ctrlQ;
      default:   prdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              irq
);

  uartStrobes_t     strobes;
  rdSel_e           rdSel;
  logic [31:0]      ctrlQ;
  logic             fifoEmpty;
  logic [CNT_W-1:0] rxCount;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  generate
    if (ADDR_W > 8) begin : g_highAddr
      logic unusedHighAddr;
      assign unusedHighAddr = ^paddr[ADDR_W-1:8];
    end
  endgenerate

  uart_regs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .addrLow(paddr[7:0]), .pwdata(pwdata), .rxValid(rxValid), .rxReady(rxReady),
    .txReady(txReady), .fifoEmpty(fifoEmpty), .strobes(strobes), .rdSel(rdSel),
    .ctrlQ(ctrlQ), .txValid(txValid), .txData(txData), .irq(irq)
  );

  uart_regs_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel), .ctrlQ(ctrlQ),
    .rxData(rxData), .rxReady(rxReady), .fifoEmpty(fifoEmpty),
    .rxCount(rxCount), .prdata(prdata)
  );

endmodule

// File: rtl/uart_apb_regs_chk.sv
module uart_apb_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid,
  input logic              txReady,
  input logic              irq,
  input logic [31:0]       ctrlQ,
  input logic [CNT_W-1:0]  rxCount
);

  assert_apb_ok_R11: assert property (@(posedge clk) disable iff (!rstN)
    pready && !pslverr);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past((rxValid && rxReady && ctrlQ[0] && ctrlQ[2]) ||
                  (txValid && txReady && ctrlQ[3])));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));

  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (ctrlQ[1] && psel && penable && pwrite));

  assert_ctrl_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite && paddr[7:0] == 8'h08) |=> (ctrlQ == $past(pwdata)));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && !pwrite && paddr[7:0] == 8'h00 && rxCount == '0) |-> (prdata == 32'h0));

endmodule

bind uart_apb_regs uart_apb_regs_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .rxValid(rxValid), .rxReady(rxReady), .txValid(txValid),
  .txReady(txReady), .irq(irq), .ctrlQ(ctrlQ), .rxCount(rxCount)
);

// File: tb/tb_uart_apb_regs.sv
module tb_uart_apb_regs;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0;
  logic rxReady;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b1;
  logic irq;

  always #2 clk = ~clk;

  uart_apb_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (.*);

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  byte unsigned q[$];
  logic [31:0] mCtrl;
  bit mIrq;

  task automatic chk(string sig, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s (phase %s) t=%0t: actual %h expected %h", req, sig, curReq, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    logic [31:0] s = 32'h6;
    s[0]  = (q.size() > 0);
    s[8]  = (q.size() >= DEPTH / 2);
    s[10] = (q.size() == DEPTH);
    return s;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      q.delete();
      mCtrl = '0;
      mIrq = 0;
    end else begin
      logic acc, isData, expTxV, expRdy, rxAcc, txDone, pop;
      logic [7:0] off;
      logic [31:0] expRd;
      string rdReq;
      acc = psel && penable;
      off = paddr[7:0];
      isData = (off == 8'h00) || (off == 8'h03);
      expRdy = (q.size() < DEPTH);
      expTxV = acc && pwrite && isData && mCtrl[1];
      chk("pready/pslverr", "R11", {30'b0, pready, pslverr}, 32'h2);
      chk("rxReady", "R9", {31'b0, rxReady}, {31'b0, expRdy});
      chk("irq", "R8", {31'b0, irq}, {31'b0, mIrq});
      chk("txValid", "R6", {31'b0, txValid}, {31'b0, expTxV});
      if (expTxV) chk("txData", "R6", {24'b0, txData}, {24'b0, pwdata[7:0]});
      if (acc && !pwrite) begin
        if (isData) begin
          expRd = (q.size() > 0) ? {24'b0, q[0]} : 32'h0; rdReq = "R3";
        end else if (off == 8'h04) begin
          expRd = expStatus(); rdReq = "R2";
        end else if (off == 8'h08) begin
          expRd = mCtrl; rdReq = "R5";
        end else begin
          expRd = 32'h0; rdReq = "R7";
        end
        chk("prdata", rdReq, prdata, expRd);
      end
      // advance model with this cycle's inputs
      rxAcc  = rxValid && expRdy && mCtrl[0];
      txDone = expTxV && txReady;
      pop    = acc && !pwrite && isData && (q.size() > 0);
      mIrq   = (rxAcc && mCtrl[2]) || (txDone && mCtrl[3]);
      if (pop) void'(q.pop_front());
      if (rxAcc) q.push_back(rxData);
      if (acc && pwrite && off == 8'h08) mCtrl = pwdata;
    end
  end

  task automatic apb(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rxPulse(input logic [7:0] b);
    @(posedge clk); #1;
    rxValid = 1; rxData = b;
    @(posedge clk); #1;
    rxValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(4);
    @(posedge clk); #1 rstN = 1;
    // R1: reset values
    curReq = "R1";
    idle(2);
    apb(0, 12'h004, 0);
    apb(0, 12'h008, 0);
    apb(0, 12'h000, 0);
    // R5: control read/write
    curReq = "R5";
    apb(1, 12'h008, 32'hA5A5_5AF0);
    apb(0, 12'h008, 0);
    apb(1, 12'h008, 32'h8000_0000);
    apb(0, 12'h008, 0);
    // R4: receive disabled discards bytes
    curReq = "R4";
    apb(1, 12'h008, 32'h0000_0004);
    rxPulse(8'h11);
    rxPulse(8'h22);
    idle(2);
    apb(0, 12'h004, 0);
    apb(0, 12'h000, 0);
    // R3 / R2: receive and pop
    curReq = "R3";
    apb(1, 12'h008, 32'h0000_0005);
    rxPulse(8'h3C);
    idle(1);
    rxPulse(8'hC3);
    rxPulse(8'h7E);
    apb(0, 12'h004, 0);
    apb(0, 12'h000, 0);
    apb(0, 12'h003, 0);
    apb(0, 12'h004, 0);
    apb(0, 12'h000, 0);
    apb(0, 12'h000, 0);
    apb(0, 12'h004, 0);
    // R9 / R2: fill to full, drain across half boundary
    curReq = "R9";
    apb(1, 12'h008, 32'h0000_0001);
    @(posedge clk); #1;
    rxValid = 1;
    for (int i = 0; i < DEPTH + 4; i++) begin
      rxData = 8'(8'h40 + i);
      @(posedge clk); #1;
    end
    rxValid = 0;
    curReq = "R2";
    apb(0, 12'h004, 0);
    for (int i = 0; i < DEPTH / 2; i++) apb(0, 12'h000, 0);
    apb(0, 12'h004, 0);
    apb(0, 12'h000, 0);
    apb(0, 12'h004, 0);
    for (int i = 0; i < DEPTH; i++) apb(0, 12'h003, 0);
    // R6 / R10: transmit
    curReq = "R6";
    apb(1, 12'h008, 32'h0000_000A);
    txReady = 1;
    apb(1, 12'h000, 32'h0000_01A5);
    apb(1, 12'h003, 32'h0000_005A);
    curReq = "R10";
    txReady = 0;
    apb(1, 12'h000, 32'h0000_00FF);
    txReady = 1;
    curReq = "R6";
    apb(1, 12'h008, 32'h0000_0008);
    apb(1, 12'h000, 32'h0000_0077);
    // R8: coincident receive and transmit causes
    curReq = "R8";
    apb(1, 12'h008, 32'h0000_000F);
    @(posedge clk); #1;
    rxValid = 1; rxData = 8'h99;
    apb(1, 12'h000, 32'h0000_0066);
    rxValid = 0;
    idle(2);
    for (int i = 0; i < 6; i++) apb(0, 12'h000, 0);
    // R7: read-only, inert and unknown offsets
    curReq = "R7";
    apb(1, 12'h004, 32'hFFFF_FFFF);
    apb(0, 12'h004, 0);
    apb(1, 12'h00C, 32'h1234_5678);
    apb(0, 12'h00C, 0);
    apb(0, 12'h010, 0);
    apb(0, 12'h014, 0);
    apb(1, 12'h020, 32'hDEAD_BEEF);
    apb(0, 12'h108, 0);
    apb(0, 12'h104, 0);
    apb(0, 12'h008, 0);
    idle(3);
    summary();
  end

endmodule